// File: doc/BRIEF.md
# Power-Safe Debug Halt Holder

This block lives in an always-on debug power domain next to a processor core that may be switched off and back on. It keeps a debugger's halt request and an event-catch arm bit alive while the core is unpowered. It also keeps a lock flag that system software raises before it saves debug state. It decides when a held halt may go to the core. That requires the core to be powered and the debug authentication inputs to allow halting in the core's current security state.

When the catch arm bit is set and the core signals the end of its power-up sequence, the block records a catch event. That event asks for debug entry in the same way a halt does. The request to the core is a level that stays high until the core acknowledges entry into debug state, and that acknowledge retires everything pending at once. A small register port lets the debugger set, inspect and clear this state at any time, whatever the core's power state.

Top module: `dbg_halt_keeper`

## Requirements
- R1: A synchronous active-high debug-domain reset clears the held halt, the catch arm bit, the lock flag, any pending catch event and `entry_req`. Core power and core events have no effect on this state.
- R2: A write to offset 0x0 with data bit 0 equal to 1 sets the held halt, also while `core_pwr_ok` is 0. A write with bit 0 equal to 0 changes nothing. A read of offset 0x0 returns the held halt in bit 0 and zeros above it.
- R3: `entry_req` rises only in the cycle after one where `core_pwr_ok` is 1, something is held, and authentication allows halting. Authentication allows halting when `dbg_en` is 1 and either `core_secure` is 0 or `sec_dbg_en` is 1.
- R4: A held halt is kept while the core is unpowered or unauthenticated. If `core_pwr_ok` drops, `entry_req` falls at the next edge, but the held state remains.
- R5: Offset 0x4 bit 0 is the catch arm bit, readable and writable. Core power loss leaves it unchanged.
- R6: When the catch arm bit is 1 and `core_pwrup_done` is 1 while `core_pwr_ok` is 1, a catch event is held. That event then drives `entry_req` under the rule in R3.
- R7: Offset 0x8 bit 0 is the lock flag, readable and writable. Core power loss leaves it unchanged.
- R8: Once raised, `entry_req` stays high while power holds and `entry_ack` is 0. An edge with both `entry_req` and `entry_ack` high clears `entry_req` and all held requests. `entry_ack` while `entry_req` is 0 is ignored.
- R9: A halt and a catch event that are held together produce one request, and a single acknowledge retires both. A new halt write or catch event in the acknowledge cycle is kept.
- R10: Offsets other than 0x0, 0x4 and 0x8 read as zero, and writes to them have no effect. The port has no error signal and behaves identically whether or not the core is powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug-domain clock |
| rst | input | 1 | Debug-domain synchronous reset, active high |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| core_pwr_ok | input | 1 | Core power domain is up |
| core_pwrup_done | input | 1 | One-cycle pulse at the end of core power-up |
| core_secure | input | 1 | Core is in secure state |
| dbg_en | input | 1 | Invasive debug allowed |
| sec_dbg_en | input | 1 | Secure invasive debug allowed |
| entry_req | output | 1 | Debug-state entry request to the core |
| entry_ack | input | 1 | Core has entered debug state |

## Verification
The halt path is tried with a halt written while the core is off and then released in steps. First power returns with no authentication, then the core is secure with only the non-secure enable, and finally full secure authentication is given. This separates the power gate from each term of the authentication rule. A power cycle between steps shows that the held state survives. Separate runs cover a catch event alone, a catch event together with a halt under one acknowledge, a stray acknowledge, a power drop while a request is up, and writes of zero or to unmapped offsets. Together these tell retention apart from delivery and from the acknowledge rule.

// File: rtl/dbg_keep_pkg.sv
package dbg_keep_pkg;

    parameter int ADDR_W = 4;
    parameter int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_HALT  = ADDR_W'(4'h0);
    localparam logic [ADDR_W-1:0] OFF_CATCH = ADDR_W'(4'h4);
    localparam logic [ADDR_W-1:0] OFF_LOCK  = ADDR_W'(4'h8);

    typedef enum logic [1:0] {
        REG_NONE,
        REG_HALT,
        REG_CATCH,
        REG_LOCK
    } reg_sel_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic pwr_ok;
        logic pwrup_done;
        logic secure;
        logic dbg_en;
        logic sec_dbg_en;
    } core_state_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e r;
        unique case (a)
            OFF_HALT:  r = REG_HALT;
            OFF_CATCH: r = REG_CATCH;
            OFF_LOCK:  r = REG_LOCK;
            default:   r = REG_NONE;
        endcase
        return r;
    endfunction

    function automatic logic halt_allowed(input core_state_t c);
        return c.dbg_en && (!c.secure || c.sec_dbg_en);
    endfunction

endpackage

// File: rtl/dbg_keep_regs.sv
module dbg_keep_regs
    import dbg_keep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              halt_held,
    output logic              halt_set,
    output logic              catch_arm,
    output logic              os_lock,
    output logic [DATA_W-1:0] rdata
);
    reg_sel_e sel_now;
    logic     wr_fire;
    logic     rd_fire;

    always_comb begin
        sel_now = decode_addr(req.addr);
        wr_fire = req.sel && req.wr;
        rd_fire = req.sel && !req.wr;
    end

    assign halt_set = wr_fire && (sel_now == REG_HALT) && req.wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            catch_arm <= 1'b0;
            os_lock   <= 1'b0;
        end else if (wr_fire) begin
            if (sel_now == REG_CATCH) catch_arm <= req.wdata[0];
            if (sel_now == REG_LOCK)  os_lock   <= req.wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_fire) begin
            unique case (sel_now)
                REG_HALT:  rdata[0] = halt_held;
                REG_CATCH: rdata[0] = catch_arm;
                REG_LOCK:  rdata[0] = os_lock;
                default:   rdata    = '0;
            endcase
        end
    end
endmodule

// File: rtl/dbg_keep_pend.sv
module dbg_keep_pend
    import dbg_keep_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        halt_set,
    input  logic        catch_arm,
    input  core_state_t core,
    input  logic        retire,
    output logic        halt_held,
    output logic        catch_held
);
    logic catch_fire;

    assign catch_fire = catch_arm && core.pwr_ok && core.pwrup_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_held  <= 1'b0;
            catch_held <= 1'b0;
        end else begin
            if (halt_set)      halt_held <= 1'b1;
            else if (retire)   halt_held <= 1'b0;
            if (catch_fire)    catch_held <= 1'b1;
            else if (retire)   catch_held <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_keep_deliver.sv
module dbg_keep_deliver
    import dbg_keep_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        any_held,
    input  core_state_t core,
    input  logic        ack,
    output logic        req,
    output logic        retire
);
    logic permit;

    assign permit = halt_allowed(core);
    assign retire = req && ack;

    always_ff @(posedge clk) begin
        if (rst)              req <= 1'b0;
        else if (!core.pwr_ok) req <= 1'b0;
        else if (retire)      req <= 1'b0;
        else if (!req)        req <= any_held && permit;
    end
endmodule

// File: rtl/dbg_halt_keeper.sv
module dbg_halt_keeper
    import dbg_keep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              core_pwr_ok,
    input  logic              core_pwrup_done,
    input  logic              core_secure,
    input  logic              dbg_en,
    input  logic              sec_dbg_en,
    output logic              entry_req,
    input  logic              entry_ack
);
    bus_req_t    breq;
    core_state_t cst;
    logic        halt_set;
    logic        catch_arm;
    logic        os_lock;
    logic        halt_held;
    logic        catch_held;
    logic        retire;

    always_comb begin
        breq.sel       = bus_sel;
        breq.wr        = bus_wr;
        breq.addr      = bus_addr;
        breq.wdata     = bus_wdata;
        cst.pwr_ok     = core_pwr_ok;
        cst.pwrup_done = core_pwrup_done;
        cst.secure     = core_secure;
        cst.dbg_en     = dbg_en;
        cst.sec_dbg_en = sec_dbg_en;
    end

    dbg_keep_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (breq),
        .halt_held (halt_held),
        .halt_set  (halt_set),
        .catch_arm (catch_arm),
        .os_lock   (os_lock),
        .rdata     (bus_rdata)
    );

    dbg_keep_pend u_pend (
        .clk        (clk),
        .rst        (rst),
        .halt_set   (halt_set),
        .catch_arm  (catch_arm),
        .core       (cst),
        .retire     (retire),
        .halt_held  (halt_held),
        .catch_held (catch_held)
    );

    dbg_keep_deliver u_dlv (
        .clk      (clk),
        .rst      (rst),
        .any_held (halt_held || catch_held),
        .core     (cst),
        .ack      (entry_ack),
        .req      (entry_req),
        .retire   (retire)
    );
endmodule

// File: rtl/dbg_halt_keeper_chk.sv
module dbg_halt_keeper_chk
    import dbg_keep_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              core_pwr_ok,
    input logic              core_secure,
    input logic              dbg_en,
    input logic              sec_dbg_en,
    input logic              entry_req,
    input logic              entry_ack,
    input logic              halt_held,
    input logic              catch_held
);
    logic auth_ok;
    assign auth_ok = dbg_en && (!core_secure || sec_dbg_en);

    p_rise_gated_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(entry_req) |-> $past(core_pwr_ok) && $past(auth_ok));

    p_rise_needs_held_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(entry_req) |-> $past(halt_held || catch_held));

    p_ack_drops_r8: assert property (@(posedge clk) disable iff (rst)
        entry_req && entry_ack |=> !entry_req);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        entry_req && !entry_ack && core_pwr_ok |=> entry_req);

    p_pwr_loss_r4: assert property (@(posedge clk) disable iff (rst)
        !core_pwr_ok |=> !entry_req);

    p_halt_clear_only_ack_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(halt_held) |-> $past(entry_req && entry_ack));

    p_write_sets_r2: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_wr && bus_addr == OFF_HALT && bus_wdata[0] |=> halt_held);
endmodule

bind dbg_halt_keeper dbg_halt_keeper_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .core_pwr_ok (core_pwr_ok),
    .core_secure (core_secure),
    .dbg_en      (dbg_en),
    .sec_dbg_en  (sec_dbg_en),
    .entry_req   (entry_req),
    .entry_ack   (entry_ack),
    .halt_held   (halt_held),
    .catch_held  (catch_held)
);

// File: tb/dbg_halt_keeper_test.sv
module dbg_halt_keeper_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        core_pwr_ok, core_pwrup_done, core_secure, dbg_en, sec_dbg_en;
    logic        entry_req, entry_ack;

    int n_run = 0;
    int n_bad = 0;
    int m_halt, m_cp, m_arm, m_lock, m_req;

    always #(PERIOD/2) clk = ~clk;

    dbg_halt_keeper uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_pwr_ok(core_pwr_ok), .core_pwrup_done(core_pwrup_done),
        .core_secure(core_secure), .dbg_en(dbg_en), .sec_dbg_en(sec_dbg_en),
        .entry_req(entry_req), .entry_ack(entry_ack)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: reference model advances, then entry_req is compared
    task automatic tick(input string tag);
        int auth, ackd, wh, cev, n_halt, n_cp, n_req;
        @(posedge clk);
        if (rst) begin
            m_halt = 0; m_cp = 0; m_arm = 0; m_lock = 0; m_req = 0;
        end else begin
            auth = dbg_en && (!core_secure || sec_dbg_en);
            ackd = m_req && entry_ack;
            wh   = bus_sel && bus_wr && bus_addr == 4'h0 && bus_wdata[0];
            cev  = core_pwrup_done && core_pwr_ok && m_arm;
            n_halt = wh ? 1 : (ackd ? 0 : m_halt);
            n_cp   = cev ? 1 : (ackd ? 0 : m_cp);
            if (!core_pwr_ok) n_req = 0;
            else if (ackd)    n_req = 0;
            else if (m_req)   n_req = 1;
            else              n_req = (m_halt || m_cp) && auth;
            if (bus_sel && bus_wr && bus_addr == 4'h4) m_arm  = bus_wdata[0];
            if (bus_sel && bus_wr && bus_addr == 4'h8) m_lock = bus_wdata[0];
            m_halt = n_halt; m_cp = n_cp; m_req = n_req;
        end
        #1;
        check(tag, int'(entry_req), m_req);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick(tag);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, input int exp, input string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        check(tag, int'(bus_rdata), exp);
        tick(tag);
        bus_sel = 0;
    endtask

    task automatic power(input logic on, input string tag);
        core_pwr_ok = on;
        tick(tag);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        rst = 1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        core_pwr_ok = 0; core_pwrup_done = 0; core_secure = 0;
        dbg_en = 0; sec_dbg_en = 0; entry_ack = 0;
        m_halt = 0; m_cp = 0; m_arm = 0; m_lock = 0; m_req = 0;
        idle(3, "R1");
        rst = 0;
        rd(4'h0, 0, "R1 halt after reset");
        rd(4'h4, 0, "R1 catch after reset");
        rd(4'h8, 0, "R1 lock after reset");

        // R2 / R10: halt written with core off, readable, no request
        wr(4'h0, 32'h1, "R2 write while off");
        rd(4'h0, 1, "R2 read while off");
        idle(2, "R3 no req when off");
        // R3: powered but no authentication
        power(1, "R3");
        idle(3, "R3 no dbg_en");
        core_secure = 1; dbg_en = 1;
        idle(3, "R3 secure without sec_dbg_en");
        // R4: power cycle keeps the halt
        power(0, "R4");
        idle(2, "R4 off");
        rd(4'h0, 1, "R4 retained through power loss");
        power(1, "R4 back");
        sec_dbg_en = 1;
        idle(2, "R3 full auth raises req");
        check("R3 req high", int'(entry_req), 1);
        idle(3, "R8 hold");
        check("R8 held without ack", int'(entry_req), 1);
        entry_ack = 1; tick("R8 ack edge"); entry_ack = 0;
        check("R8 req cleared", int'(entry_req), 0);
        rd(4'h0, 0, "R8 halt retired");
        // stray ack and write of zero
        entry_ack = 1; idle(2, "R8 stray ack"); entry_ack = 0;
        wr(4'h0, 32'h0, "R2 write zero");
        rd(4'h0, 0, "R2 zero no effect");
        idle(2, "R2 no req after zero write");

        // non-secure needs only dbg_en
        core_secure = 0; sec_dbg_en = 0;
        wr(4'h0, 32'h1, "R3 nonsecure");
        idle(2, "R3 nonsecure req");
        check("R3 nonsecure req", int'(entry_req), 1);
        // R4: power drop withdraws request, halt stays
        power(0, "R4 drop");
        check("R4 req dropped", int'(entry_req), 0);
        rd(4'h0, 1, "R4 halt kept after drop");
        power(1, "R4 restore");
        idle(1, "R4 re-request");
        entry_ack = 1; tick("R8 ack"); entry_ack = 0;

        // R5 / R6: catch armed while off, survives, fires on power-up done
        power(0, "R5");
        wr(4'h4, 32'h1, "R5 arm while off");
        idle(2, "R5 off");
        power(1, "R5 on");
        rd(4'h4, 1, "R5 arm retained");
        idle(2, "R6 no req before done");
        check("R6 no req yet", int'(entry_req), 0);
        core_pwrup_done = 1; tick("R6 done pulse"); core_pwrup_done = 0;
        idle(1, "R6 req");
        check("R6 catch req", int'(entry_req), 1);
        entry_ack = 1; tick("R6 ack"); entry_ack = 0;
        idle(2, "R6 retired");

        // R9: halt and catch together, single ack
        wr(4'h0, 32'h1, "R9 halt");
        core_pwrup_done = 1; tick("R9 catch"); core_pwrup_done = 0;
        idle(1, "R9 req");
        entry_ack = 1; tick("R9 one ack"); entry_ack = 0;
        idle(3, "R9 no second req");
        check("R9 single request", int'(entry_req), 0);
        // R9: new halt in ack cycle is kept
        wr(4'h0, 32'h1, "R9 halt2");
        idle(1, "R9 req2");
        entry_ack = 1; bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 1;
        tick("R9 ack plus set"); entry_ack = 0; bus_sel = 0; bus_wr = 0;
        rd(4'h0, 1, "R9 set in ack cycle kept");
        idle(1, "R9 rerequest");
        entry_ack = 1; tick("R9 ack3"); entry_ack = 0;
        wr(4'h4, 32'h0, "R5 disarm");
        rd(4'h4, 0, "R5 disarmed");

        // R7: lock through power loss
        wr(4'h8, 32'h1, "R7 lock");
        power(0, "R7 off");
        idle(2, "R7");
        rd(4'h8, 1, "R7 lock retained");
        wr(4'h8, 32'h0, "R7 unlock while off");
        rd(4'h8, 0, "R7 unlocked");

        // R10: unmapped offsets
        wr(4'hC, 32'hFFFF_FFFF, "R10 unmapped write");
        rd(4'hC, 0, "R10 unmapped read");
        rd(4'h0, 0, "R10 halt untouched");
        rd(4'h4, 0, "R10 catch untouched");
        rd(4'h8, 0, "R10 lock untouched");

        // R1: reset clears retained state
        wr(4'h0, 32'h1, "R1 pre");
        wr(4'h8, 32'h1, "R1 pre");
        rst = 1; idle(2, "R1 reset"); rst = 0;
        rd(4'h0, 0, "R1 halt cleared");
        rd(4'h8, 0, "R1 lock cleared");

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule